// File: doc/BRIEF.md
# Oblivious Mesh Route Computation Unit

This block picks the output direction for a head flit at one router of a two-dimensional mesh. It looks only at the router's own coordinates and at the fields carried in the packet header. No congestion or buffer state enters the decision. A two-bit policy input selects one of four oblivious policies, and it is honoured only at the node where the packet is injected:

- plain X-then-Y dimension order;
- a per-packet coin flip between X-then-Y and Y-then-X order;
- two legs through a random intermediate node taken from the whole mesh;
- two legs through a random intermediate node taken from the box that the source and destination span.

At the injecting node the block writes its random choices into the header: an order bit, intermediate X and Y coordinates, and a leg (phase) bit. Every later node reads those fields and does not draw random values again. When a packet on its first leg reaches the intermediate node, the phase bit is set and routing heads for the final destination. A 16-bit linear feedback shift register supplies the random bits and advances once for every injected packet. The result, the port plus the updated header fields, is registered and appears one clock after the request.

Top module: `rc_oblivious`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. After reset `out_valid` is 0 and `out_port` is Local (0).
- R2: Port codes are Local=0, East=1 (x+1), West=2 (x-1), North=3 (y+1), South=4 (y-1). With order bit 0 the X offset to the target is removed fully before Y moves. With order bit 1, Y is removed first.
- R3: Local is produced only when the current node equals the destination and the output phase bit is 1 (final leg).
- R4: Policy 0 at injection (`in_src`=1) gives order 0, intermediate equal to the destination, and phase 1.
- R5: Policy 1 at injection gives intermediate equal to the destination and phase 1. The order bit is random per packet, and both values occur over a run of packets.
- R6: Policy 2 at injection gives order 0 and an intermediate anywhere in the mesh, including nodes outside the source/destination box. Phase is 0 unless the intermediate equals the current node.
- R7: Policy 3 at injection gives order 0 and an intermediate with each coordinate between the source and destination coordinates, inclusive. Phase follows the same rule as R6.
- R8: A flit with phase 0 whose current node equals its intermediate leaves with phase 1, and it is routed toward the destination in the same cycle.
- R9: For non-injected flits (`in_src`=0) the policy input has no effect. Order and intermediate pass through unchanged.
- R10: Each non-Local port moves one hop closer (Manhattan) to the current target. A full path takes as many hops as the source-to-destination distance under policies 0, 1 and 3, and the source-to-intermediate distance plus the intermediate-to-destination distance under policy 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Head flit present for route computation |
| in_src | input | 1 | Flit is being injected at this node (choices made here) |
| in_mode | input | 2 | Policy: 0 XY, 1 random order, 2 mesh intermediate, 3 box intermediate |
| cur_x | input | XW | This node's X coordinate |
| cur_y | input | YW | This node's Y coordinate |
| dst_x | input | XW | Destination X from the header |
| dst_y | input | YW | Destination Y from the header |
| hdr_order | input | 1 | Header order bit (0 X first, 1 Y first) |
| hdr_mid_x | input | XW | Header intermediate X |
| hdr_mid_y | input | YW | Header intermediate Y |
| hdr_phase | input | 1 | Header phase bit (1 = final leg) |
| out_valid | output | 1 | Result valid |
| out_port | output | 3 | Selected output port |
| out_order | output | 1 | Updated order bit |
| out_mid_x | output | XW | Updated intermediate X |
| out_mid_y | output | YW | Updated intermediate Y |
| out_phase | output | 1 | Updated phase bit |

## Verification
The bench walks packets hop by hop, feeding each result back as the next node's header. A design that moves the wrong way or flips the order would then miss the hop count, or circle until the walk limit. It sends flits that sit exactly on their intermediate with phase 0. A design that misses the phase flip would send them Local, or away from the destination. It injects packets whose intermediate lands on the source, and packets whose source equals the destination, where phase and Local must appear at once. It also draws mesh-wide intermediates for a small box. A design that confined them to the box, or that ignored the coin flip in random-order mode, is caught by statistics over many packets.

// File: rtl/rc_pkg.sv
package rc_pkg;
    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_EAST  = 3'd1,
        PORT_WEST  = 3'd2,
        PORT_NORTH = 3'd3,
        PORT_SOUTH = 3'd4
    } port_e;

    typedef enum logic [1:0] {
        POL_XY     = 2'd0,
        POL_RORDER = 2'd1,
        POL_MESH   = 2'd2,
        POL_BOX    = 2'd3
    } policy_e;

    localparam int RNG_W = 16;
endpackage

// File: rtl/rc_lfsr.sv
module rc_lfsr #(
    parameter int          W    = 16,
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] state
);
    logic [W-1:0] lfsr_d, lfsr_q;

    // taps for x^16 + x^14 + x^13 + x^11 + 1
    always_comb begin
        lfsr_d = lfsr_q;
        if (step) begin
            lfsr_d = {lfsr_q[W-2:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= W'(SEED);
        else        lfsr_q <= lfsr_d;
    end

    assign state = lfsr_q;
endmodule

// File: rtl/rc_mid_axis.sv
module rc_mid_axis #(
    parameter int DIM = 4,
    parameter int W   = 2,
    parameter int RW  = 4
) (
    input  logic          box_mode,
    input  logic [W-1:0]  cur,
    input  logic [W-1:0]  dst,
    input  logic [RW-1:0] rnd,
    output logic [W-1:0]  mid
);
    logic [W-1:0]  lo, hi;
    logic [RW-1:0] span, off, dim_w, any_pos;

    always_comb begin
        lo      = (cur <= dst) ? cur : dst;
        hi      = (cur <= dst) ? dst : cur;
        span    = RW'(hi) - RW'(lo) + RW'(1);
        off     = rnd % span;
        dim_w   = RW'(DIM);
        any_pos = rnd % dim_w;
        if (box_mode) mid = W'(RW'(lo) + off);
        else          mid = W'(any_pos);
    end
endmodule

// File: rtl/rc_port_sel.sv
module rc_port_sel
    import rc_pkg::*;
#(
    parameter int XW = 2,
    parameter int YW = 2
) (
    input  logic [XW-1:0] cx,
    input  logic [YW-1:0] cy,
    input  logic [XW-1:0] tx,
    input  logic [YW-1:0] ty,
    input  logic          y_first,
    output port_e         port
);
    port_e x_port, y_port;

    always_comb begin
        x_port = (tx > cx) ? PORT_EAST  : PORT_WEST;
        y_port = (ty > cy) ? PORT_NORTH : PORT_SOUTH;
        if (cx == tx && cy == ty) port = PORT_LOCAL;
        else if (!y_first)        port = (cx != tx) ? x_port : y_port;
        else                      port = (cy != ty) ? y_port : x_port;
    end
endmodule

// File: rtl/rc_oblivious.sv
module rc_oblivious
    import rc_pkg::*;
#(
    parameter int          MESH_X = 4,
    parameter int          MESH_Y = 4,
    parameter logic [15:0] SEED   = 16'hACE1,
    localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
    localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_src,
    input  logic [1:0]    in_mode,
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    input  logic          hdr_order,
    input  logic [XW-1:0] hdr_mid_x,
    input  logic [YW-1:0] hdr_mid_y,
    input  logic          hdr_phase,
    output logic          out_valid,
    output logic [2:0]    out_port,
    output logic          out_order,
    output logic [XW-1:0] out_mid_x,
    output logic [YW-1:0] out_mid_y,
    output logic          out_phase
);
    // two spare random bits per axis keep the modulo bias small
    localparam int RXW = XW + 2;
    localparam int RYW = YW + 2;

    typedef struct packed {
        logic          valid;
        port_e         port;
        logic          order;
        logic [XW-1:0] mid_x;
        logic [YW-1:0] mid_y;
        logic          phase;
    } rc_state_t;

    rc_state_t     r_d, r_q;
    logic [RNG_W-1:0] rng;
    logic [RXW-1:0] rnd_x;
    logic [RYW-1:0] rnd_y;
    logic           rnd_order;
    logic           box_sel;
    logic [XW-1:0]  pick_x;
    logic [YW-1:0]  pick_y;
    logic           eff_order, eff_phase, leg_done, phase_n;
    logic [XW-1:0]  eff_mid_x, tgt_x;
    logic [YW-1:0]  eff_mid_y, tgt_y;
    port_e          port_n;
    policy_e        pol;

    rc_lfsr #(.W(RNG_W), .SEED(SEED)) u_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (in_valid && in_src),
        .state (rng)
    );

    assign rnd_x     = rng[RXW-1:0];
    assign rnd_y     = rng[RXW+RYW-1:RXW];
    assign rnd_order = rng[RNG_W-1];
    assign pol       = policy_e'(in_mode);
    assign box_sel   = (pol == POL_BOX);

    rc_mid_axis #(.DIM(MESH_X), .W(XW), .RW(RXW)) u_mid_x (
        .box_mode (box_sel),
        .cur      (cur_x),
        .dst      (dst_x),
        .rnd      (rnd_x),
        .mid      (pick_x)
    );

    rc_mid_axis #(.DIM(MESH_Y), .W(YW), .RW(RYW)) u_mid_y (
        .box_mode (box_sel),
        .cur      (cur_y),
        .dst      (dst_y),
        .rnd      (rnd_y),
        .mid      (pick_y)
    );

    // header fields as seen by this node: chosen here when injecting
    always_comb begin
        eff_order = hdr_order;
        eff_mid_x = hdr_mid_x;
        eff_mid_y = hdr_mid_y;
        eff_phase = hdr_phase;
        if (in_src) begin
            unique case (pol)
                POL_XY: begin
                    eff_order = 1'b0;
                    eff_mid_x = dst_x;
                    eff_mid_y = dst_y;
                    eff_phase = 1'b1;
                end
                POL_RORDER: begin
                    eff_order = rnd_order;
                    eff_mid_x = dst_x;
                    eff_mid_y = dst_y;
                    eff_phase = 1'b1;
                end
                default: begin
                    eff_order = 1'b0;
                    eff_mid_x = pick_x;
                    eff_mid_y = pick_y;
                    eff_phase = 1'b0;
                end
            endcase
        end
        leg_done = (cur_x == eff_mid_x) && (cur_y == eff_mid_y);
        phase_n  = eff_phase | leg_done;
        tgt_x    = phase_n ? dst_x : eff_mid_x;
        tgt_y    = phase_n ? dst_y : eff_mid_y;
    end

    rc_port_sel #(.XW(XW), .YW(YW)) u_port (
        .cx      (cur_x),
        .cy      (cur_y),
        .tx      (tgt_x),
        .ty      (tgt_y),
        .y_first (eff_order),
        .port    (port_n)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = in_valid;
        if (in_valid) begin
            r_d.port  = port_n;
            r_d.order = eff_order;
            r_d.mid_x = eff_mid_x;
            r_d.mid_y = eff_mid_y;
            r_d.phase = phase_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{valid: 1'b0, port: PORT_LOCAL, order: 1'b0,
                     mid_x: '0, mid_y: '0, phase: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.valid;
    assign out_port  = r_q.port;
    assign out_order = r_q.order;
    assign out_mid_x = r_q.mid_x;
    assign out_mid_y = r_q.mid_y;
    assign out_phase = r_q.phase;
endmodule

// File: rtl/rc_oblivious_chk.sv
module rc_oblivious_chk #(
    parameter int MESH_X = 4,
    parameter int MESH_Y = 4,
    localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
    localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_src,
    input logic [1:0]    in_mode,
    input logic [XW-1:0] cur_x,
    input logic [YW-1:0] cur_y,
    input logic [XW-1:0] dst_x,
    input logic [YW-1:0] dst_y,
    input logic          hdr_order,
    input logic [XW-1:0] hdr_mid_x,
    input logic [YW-1:0] hdr_mid_y,
    input logic          hdr_phase,
    input logic          out_valid,
    input logic [2:0]    out_port,
    input logic          out_order,
    input logic [XW-1:0] out_mid_x,
    input logic [YW-1:0] out_mid_y,
    input logic          out_phase
);
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_PORT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_port <= 3'd4); // R2
    AST_LOCAL_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_port == 3'd0) |-> out_phase); // R3
    AST_XY_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_src && in_mode == 2'd0) |=>
        (!out_order && out_phase && out_mid_x == $past(dst_x) && out_mid_y == $past(dst_y))); // R4
    AST_MESH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_src && in_mode == 2'd2) |=>
        (out_phase == (out_mid_x == $past(cur_x) && out_mid_y == $past(cur_y)))); // R6
    AST_BOX_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_src && in_mode == 2'd3) |=>
        ((($past(cur_x) <= $past(dst_x)) ? (out_mid_x >= $past(cur_x) && out_mid_x <= $past(dst_x))
                                         : (out_mid_x >= $past(dst_x) && out_mid_x <= $past(cur_x))) &&
         (($past(cur_y) <= $past(dst_y)) ? (out_mid_y >= $past(cur_y) && out_mid_y <= $past(dst_y))
                                         : (out_mid_y >= $past(dst_y) && out_mid_y <= $past(cur_y))))); // R7
    AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_src && !hdr_phase && cur_x == hdr_mid_x && cur_y == hdr_mid_y) |=> out_phase); // R8
    AST_FWD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_src) |=>
        (out_order == $past(hdr_order) && out_mid_x == $past(hdr_mid_x) && out_mid_y == $past(hdr_mid_y))); // R9
endmodule

bind rc_oblivious rc_oblivious_chk #(.MESH_X(MESH_X), .MESH_Y(MESH_Y)) u_chk (.*);

// File: tb/tb_rc_oblivious.sv
`timescale 1ns/1ps
module tb_rc_oblivious;
    localparam int MX = 4;
    localparam int MY = 4;
    localparam int XW = 2;
    localparam int YW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_src = 1'b0;
    logic [1:0]    in_mode = '0;
    logic [XW-1:0] cur_x = '0, dst_x = '0, hdr_mid_x = '0;
    logic [YW-1:0] cur_y = '0, dst_y = '0, hdr_mid_y = '0;
    logic          hdr_order = 1'b0, hdr_phase = 1'b0;
    logic          out_valid, out_order, out_phase;
    logic [2:0]    out_port;
    logic [XW-1:0] out_mid_x;
    logic [YW-1:0] out_mid_y;

    int checks = 0, errors = 0;
    int ord_ones = 0, ord_zeros = 0, outside_box = 0;

    typedef struct {
        bit src; int mode; int cx, cy, dx, dy; int hord, hmx, hmy, hph;
    } item_t;
    item_t q[$];

    always #2 clk = ~clk; // 250 MHz

    rc_oblivious #(.MESH_X(MX), .MESH_Y(MY)) dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int ref_port(input int cx, cy, tx, ty, ord);
        if (cx == tx && cy == ty) return 0;
        if (ord == 0) begin
            if (cx != tx) return (tx > cx) ? 1 : 2;
            return (ty > cy) ? 3 : 4;
        end
        if (cy != ty) return (ty > cy) ? 3 : 4;
        return (tx > cx) ? 1 : 2;
    endfunction

    function automatic bit in_rng(input int v, a, b);
        return (a <= b) ? (v >= a && v <= b) : (v >= b && v <= a);
    endfunction

    task automatic check_item(input item_t it);
        int mx, my, ph, tx, ty, exp_port, nx, ny;
        mx = int'(out_mid_x); my = int'(out_mid_y); ph = int'(out_phase);
        if (it.src) begin
            case (it.mode)
                0: begin
                    chk(out_order == 0 && mx == it.dx && my == it.dy, "R4 header", mx*4+my, it.dx*4+it.dy);
                    chk(ph == 1, "R4 phase", ph, 1);
                end
                1: begin
                    chk(mx == it.dx && my == it.dy && ph == 1, "R5 header", mx*4+my, it.dx*4+it.dy);
                    if (out_order) ord_ones++; else ord_zeros++;
                end
                2: begin
                    chk(mx < MX && my < MY && out_order == 0, "R6 mid in mesh", mx*4+my, 0);
                    chk(ph == ((mx == it.cx && my == it.cy) ? 1 : 0), "R6 phase", ph, 0);
                    if (!(in_rng(mx, it.cx, it.dx) && in_rng(my, it.cy, it.dy))) outside_box++;
                end
                default: begin
                    chk(in_rng(mx, it.cx, it.dx) && in_rng(my, it.cy, it.dy) && out_order == 0,
                        "R7 mid in box", mx*4+my, it.cx*4+it.cy);
                    chk(ph == ((mx == it.cx && my == it.cy) ? 1 : 0), "R7 phase", ph, 0);
                end
            endcase
        end else begin
            chk(int'(out_order) == it.hord && mx == it.hmx && my == it.hmy, "R9 fields kept",
                int'(out_order)*16+mx*4+my, it.hord*16+it.hmx*4+it.hmy);
            chk(ph == ((it.hph == 1 || (it.cx == it.hmx && it.cy == it.hmy)) ? 1 : 0), "R8 phase",
                ph, (it.hph == 1 || (it.cx == it.hmx && it.cy == it.hmy)) ? 1 : 0);
        end
        tx = ph ? it.dx : mx;
        ty = ph ? it.dy : my;
        exp_port = ref_port(it.cx, it.cy, tx, ty, int'(out_order));
        chk(int'(out_port) == exp_port, "R2 port", int'(out_port), exp_port);
        if (out_port == 3'd0) begin
            chk(ph == 1 && it.cx == it.dx && it.cy == it.dy, "R3 local", ph, 1);
        end else begin
            nx = it.cx + ((out_port == 3'd1) ? 1 : (out_port == 3'd2) ? -1 : 0);
            ny = it.cy + ((out_port == 3'd3) ? 1 : (out_port == 3'd4) ? -1 : 0);
            chk(iabs(nx-tx)+iabs(ny-ty) == iabs(it.cx-tx)+iabs(it.cy-ty)-1, "R10 hop closer",
                iabs(nx-tx)+iabs(ny-ty), iabs(it.cx-tx)+iabs(it.cy-ty)-1);
        end
    endtask

    // monitor: pops expectations as results appear
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) chk(1'b0, "R1 unexpected valid", 1, 0);
            else check_item(q.pop_front());
        end
    end

    // driver: one flit, expectation queued
    task automatic send(input bit src, input int mode, cx, cy, dx, dy, hord, hmx, hmy, hph);
        item_t it;
        it = '{src, mode, cx, cy, dx, dy, hord, hmx, hmy, hph};
        in_valid = 1'b1; in_src = src; in_mode = 2'(mode);
        cur_x = XW'(cx); cur_y = YW'(cy); dst_x = XW'(dx); dst_y = YW'(dy);
        hdr_order = hord[0]; hdr_mid_x = XW'(hmx); hdr_mid_y = YW'(hmy); hdr_phase = hph[0];
        q.push_back(it);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // hop-by-hop walk feeding each result back as the next header
    task automatic walk(input int mode, sx, sy, dx, dy);
        int cx, cy, hops, m0x, m0y, exp_h, p;
        cx = sx; cy = sy; hops = 0;
        send(1'b1, mode, cx, cy, dx, dy, 0, 0, 0, 0);
        #1;
        m0x = int'(out_mid_x); m0y = int'(out_mid_y);
        exp_h = (mode == 2) ? iabs(sx-m0x)+iabs(sy-m0y)+iabs(m0x-dx)+iabs(m0y-dy)
                            : iabs(sx-dx)+iabs(sy-dy);
        p = int'(out_port);
        while (p != 0 && hops < 40) begin
            cx += (p == 1) ? 1 : (p == 2) ? -1 : 0;
            cy += (p == 3) ? 1 : (p == 4) ? -1 : 0;
            hops++;
            send(1'b0, (hops * 3) % 4, cx, cy, dx, dy, int'(out_order), int'(out_mid_x),
                 int'(out_mid_y), int'(out_phase));
            #1;
            p = int'(out_port);
        end
        chk(hops == exp_h && cx == dx && cy == dy, "R10 path length", hops, exp_h);
    endtask

    initial begin
        #(4 * 200000);
        chk(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && out_port == 3'd0, "R1 reset state", int'(out_port), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: one-cycle latency then idle
        send(1'b1, 0, 1, 1, 3, 2, 0, 0, 0, 0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 idle after result", int'(out_valid), 0);
        // R3: injected at its own destination
        send(1'b1, 0, 2, 2, 2, 2, 0, 0, 0, 0);
        send(1'b1, 3, 0, 3, 0, 3, 0, 0, 0, 0);
        // R8: sitting on the intermediate with phase 0
        send(1'b0, 2, 2, 1, 0, 3, 0, 2, 1, 0);
        send(1'b0, 1, 3, 3, 3, 3, 1, 3, 3, 0);
        // R2: same geometry, both orders
        send(1'b0, 0, 1, 1, 3, 3, 0, 3, 3, 1);
        send(1'b0, 0, 1, 1, 3, 3, 1, 3, 3, 1);
        send(1'b0, 0, 3, 3, 0, 0, 0, 0, 0, 1);
        send(1'b0, 0, 3, 3, 0, 0, 1, 0, 0, 1);
        // R9: identical header under every policy value
        for (int m = 0; m < 4; m++) send(1'b0, m, 0, 2, 3, 0, 1, 1, 2, 0);
        // R5 and R6 statistics
        for (int i = 0; i < 40; i++) send(1'b1, 1, 1, 2, 3, 0, 0, 0, 0, 0);
        for (int i = 0; i < 40; i++) send(1'b1, 2, 1, 1, 2, 2, 0, 0, 0, 0);
        @(negedge clk);
        chk(ord_ones > 0 && ord_zeros > 0, "R5 both orders", ord_ones, 1);
        chk(outside_box > 0, "R6 outside box", outside_box, 1);
        // R10: complete walks under every policy
        for (int i = 0; i < 60; i++) begin
            walk(i % 4, $urandom_range(0, MX-1), $urandom_range(0, MY-1),
                 $urandom_range(0, MX-1), $urandom_range(0, MY-1));
        end
        // random single flits
        for (int i = 0; i < 300; i++) begin
            send(1'($urandom_range(0, 1)), $urandom_range(0, 3),
                 $urandom_range(0, MX-1), $urandom_range(0, MY-1),
                 $urandom_range(0, MX-1), $urandom_range(0, MY-1),
                 $urandom_range(0, 1), $urandom_range(0, MX-1), $urandom_range(0, MY-1),
                 $urandom_range(0, 1));
        end
        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R1 all results seen", q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule